// File: doc/BRIEF.md
# Infrared Port Receive FIFO and Status Logic

This block is the receive side of a fast infrared serial port, seen from the processor. Received bytes arrive on a byte stream with a valid/ready handshake. They are stored in a circular 64-entry FIFO. Software drains the FIFO by reading a data register on a simple register bus.

Three 8-bit control registers hold the port settings:
- receive enable and transmit enable;
- two interrupt enables;
- a 2-bit trigger code.

Two 8-bit status registers are computed every cycle from the FIFO occupancy and the control values. They report a receive service request, a transmit service request, FIFO not empty, and receiver sync. A single interrupt line combines the two service requests with their enables. The same flags also appear as separate output pins, for DMA or an interrupt controller. Line coding, framing and CRC are not part of this block.

Register addresses on `reg_addr`:

| Address | Register | Access |
|---|---|---|
| 0 | control A | read/write |
| 1 | control B | read/write (storage only) |
| 2 | control C | read/write |
| 3 | status A | read-only |
| 4 | status B | read-only |
| 5 | data | read pops the FIFO |
| 6, 7 | unused | read as 0, writes ignored |

Top module: `ir_rx_fifo_stat`

## Requirements
- R1: After reset every control register and both status registers read 0, `in_ready` is 0, `irq` is 0, and the FIFO is empty.
- R2: Control registers at addresses 0, 1 and 2 store all 8 bits written and read them back. Writes to status addresses 3 and 4 change no register and no flag.
- R3: A byte is accepted on a clock edge where `in_valid` and `in_ready` are both 1. Bytes are returned by reads of address 5 in arrival order, and each such read of a non-empty FIFO removes one byte. A read of address 5 while the FIFO is empty returns 0 and changes nothing.
- R4: `in_ready` is 1 exactly when control A bit 4 (receive enable) is 1 and the FIFO holds fewer than 64 bytes. A 65th byte is therefore never accepted.
- R5: The threshold comes from control C bits 1:0: code 0 gives 8, code 1 gives 16, code 2 gives 32, and code 3 gives 0. The receive request (status A bit 4 and `rx_req`) is 1 exactly when receive enable is 1 and the byte count is at least the threshold. With code 3 the request is therefore set whenever receive is enabled, even when the FIFO is empty.
- R6: The transmit request (status A bit 3 and `tx_req`) equals control A bit 3 (transmit enable).
- R7: Status B bit 2 (`not_empty`) is 1 exactly when the FIFO holds at least one byte. Status B bit 0 (`rx_sync`) equals receive enable. All other status bits read 0.
- R8: `irq` is 1 exactly when control A bit 5 and the receive request are both 1, or when control A bit 6 and the transmit request are both 1.
- R9: The flags and `irq` are combinational from the current registers and byte count. They reflect a register write, push or pop in the cycle after the clock edge that performs it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; pops the FIFO at address 5 |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| in_valid | input | 1 | Received byte is valid |
| in_data | input | 8 | Received byte |
| in_ready | output | 1 | FIFO can accept a byte |
| rx_req | output | 1 | Receive service request |
| tx_req | output | 1 | Transmit service request |
| not_empty | output | 1 | FIFO holds data |
| rx_sync | output | 1 | Receiver synchronised (follows receive enable) |
| irq | output | 1 | Combined interrupt |

## Verification
The assertions assume that `reg_wr` and `reg_rd` are never both high in the same cycle. They also assume that the byte source only counts a transfer as taken when `in_ready` was high. The bench drives one register operation at a time, with a free cycle between operations, and changes `in_valid` and `in_data` only at the falling edge. This keeps every push and pop inside the handshake that the FIFO checks rely on. Random traffic is biased toward pushes with receive enabled, so the FIFO reaches the full and threshold boundaries as well as the empty state.

// File: rtl/ir_rx_pkg.sv
package ir_rx_pkg;
  localparam int DW = 8;
  localparam int AW = 3;

  localparam logic [AW-1:0] RA_CTL_A  = 3'd0;
  localparam logic [AW-1:0] RA_CTL_B  = 3'd1;
  localparam logic [AW-1:0] RA_CTL_C  = 3'd2;
  localparam logic [AW-1:0] RA_STAT_A = 3'd3;
  localparam logic [AW-1:0] RA_STAT_B = 3'd4;
  localparam logic [AW-1:0] RA_DATA   = 3'd5;

  localparam int B_TX_EN = 3;
  localparam int B_RX_EN = 4;
  localparam int B_RX_IE = 5;
  localparam int B_TX_IE = 6;

  // Maps the 2-bit trigger code to a byte threshold.
  function automatic int trig_level(input logic [1:0] code);
    case (code)
      2'd0:    return 8;
      2'd1:    return 16;
      2'd2:    return 32;
      default: return 0;
    endcase
  endfunction

  // Returns 1 when the byte count has reached the threshold.
  function automatic logic level_met(input int count, input logic [1:0] code);
    return count >= trig_level(code);
  endfunction
endpackage

// File: rtl/ir_rx_ring.sv
module ir_rx_ring #(
  parameter int DEPTH = 64,
  parameter int W     = 8,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  output logic [W-1:0]  rdata,
  output logic [CW-1:0] count
);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [PW-1:0] LAST_PTR = PW'(DEPTH - 1);
  localparam logic [CW-1:0] ONE      = CW'(1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == LAST_PTR) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + ONE;
        2'b01:   count <= count - ONE;
        default: count <= count;
      endcase
    end
  end

  assign rdata = mem[rd_ptr];

  a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (count == FULL_CNT) |-> !push);
  a_r3_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0) |-> !pop);
  a_r3_count_up: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |=> (count == $past(count) + ONE));
  a_r3_count_down: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push) |=> (count == $past(count) - ONE));
  a_r3_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (push == pop) |=> $stable(count));
endmodule

// File: rtl/ir_rx_ctrl.sv
module ir_rx_ctrl
  import ir_rx_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] ctl_a,
  output logic [DW-1:0] ctl_b,
  output logic [DW-1:0] ctl_c
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_a <= '0;
      ctl_b <= '0;
      ctl_c <= '0;
    end else if (wr) begin
      case (addr)
        RA_CTL_A: ctl_a <= wdata;
        RA_CTL_B: ctl_b <= wdata;
        RA_CTL_C: ctl_c <= wdata;
        default: ;
      endcase
    end
  end

  a_r2_hold_a: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && addr == RA_CTL_A) |=> $stable(ctl_a));
  a_r2_hold_c: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && addr == RA_CTL_C) |=> $stable(ctl_c));
endmodule

// File: rtl/ir_rx_flags.sv
module ir_rx_flags
  import ir_rx_pkg::*;
#(
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] ctl_a,
  input  logic [DW-1:0] ctl_c,
  input  logic [CW-1:0] count,
  output logic          rx_req,
  output logic          tx_req,
  output logic          not_empty,
  output logic          rx_sync,
  output logic          irq,
  output logic [DW-1:0] stat_a,
  output logic [DW-1:0] stat_b
);
  logic rx_en;

  assign rx_en     = ctl_a[B_RX_EN];
  assign rx_req    = rx_en && level_met(int'(count), ctl_c[1:0]);
  assign tx_req    = ctl_a[B_TX_EN];
  assign not_empty = (count != '0);
  assign rx_sync   = rx_en;
  assign irq       = (ctl_a[B_RX_IE] && rx_req) || (ctl_a[B_TX_IE] && tx_req);

  always_comb begin
    stat_a = '0;
    stat_a[4] = rx_req;
    stat_a[3] = tx_req;
    stat_b = '0;
    stat_b[2] = not_empty;
    stat_b[0] = rx_sync;
  end

  a_r5_req_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    rx_req |-> rx_sync);
  a_r8_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (rx_req || tx_req));
  a_r5_code3_any: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && ctl_c[1:0] == 2'd3) |-> rx_req);
endmodule

// File: rtl/ir_rx_fifo_stat.sv
module ir_rx_fifo_stat
  import ir_rx_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [2:0]    reg_addr,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  input  logic          in_valid,
  input  logic [7:0]    in_data,
  output logic          in_ready,
  output logic          rx_req,
  output logic          tx_req,
  output logic          not_empty,
  output logic          rx_sync,
  output logic          irq
);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [DW-1:0] ctl_a, ctl_b, ctl_c, stat_a, stat_b, fifo_q;
  logic [CW-1:0] count;
  logic          push, pop, data_rd;

  assign data_rd  = reg_rd && (reg_addr == RA_DATA);
  assign in_ready = rx_sync && (count != FULL_CNT);
  assign push     = in_valid && in_ready;
  assign pop      = data_rd && not_empty;

  ir_rx_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .ctl_a(ctl_a), .ctl_b(ctl_b), .ctl_c(ctl_c)
  );

  ir_rx_ring #(.DEPTH(DEPTH), .W(DW)) u_ring (
    .clk(clk), .rst_n(rst_n), .push(push), .wdata(in_data), .pop(pop),
    .rdata(fifo_q), .count(count)
  );

  ir_rx_flags #(.CW(CW)) u_flags (
    .clk(clk), .rst_n(rst_n), .ctl_a(ctl_a), .ctl_c(ctl_c), .count(count),
    .rx_req(rx_req), .tx_req(tx_req), .not_empty(not_empty), .rx_sync(rx_sync),
    .irq(irq), .stat_a(stat_a), .stat_b(stat_b)
  );

  always_comb begin
    case (reg_addr)
      RA_CTL_A:  reg_rdata = ctl_a;
      RA_CTL_B:  reg_rdata = ctl_b;
      RA_CTL_C:  reg_rdata = ctl_c;
      RA_STAT_A: reg_rdata = stat_a;
      RA_STAT_B: reg_rdata = stat_b;
      RA_DATA:   reg_rdata = not_empty ? fifo_q : '0;
      default:   reg_rdata = '0;
    endcase
  end

  a_r4_ready_low: assert property (@(posedge clk) disable iff (!rst_n)
    (count == FULL_CNT || !ctl_a[B_RX_EN]) |-> !in_ready);
  a_r3_empty_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && count == '0) |-> (reg_rdata == '0));
  a_r7_nonempty_after_push: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |=> not_empty);
endmodule

// File: tb/test_ir_rx_fifo_stat.sv
`timescale 1ns/1ps
module test_ir_rx_fifo_stat;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic in_ready, rx_req, tx_req, not_empty, rx_sync, irq;

  always #2.5 clk = ~clk;

  ir_rx_fifo_stat i_ir_rx_fifo_stat (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .rx_req(rx_req), .tx_req(tx_req), .not_empty(not_empty),
    .rx_sync(rx_sync), .irq(irq)
  );

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;
  logic [7:0] m_a = '0, m_b = '0, m_c = '0;
  logic [7:0] q[$];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int thr_of(input logic [1:0] c);
    return (c == 2'd3) ? 0 : (8 << c);
  endfunction
  function automatic logic e_rx_req();
    return m_a[4] && (q.size() >= thr_of(m_c[1:0]));
  endfunction
  function automatic logic [7:0] e_stat_a();
    return {3'b000, e_rx_req(), m_a[3], 3'b000};
  endfunction
  function automatic logic [7:0] e_stat_b();
    return {5'b00000, q.size() != 0, 1'b0, m_a[4]};
  endfunction

  task automatic check_flags();
    chk("R5 rx_req", rx_req, e_rx_req());
    chk("R6 tx_req", tx_req, m_a[3]);
    chk("R7 not_empty", not_empty, q.size() != 0);
    chk("R7 rx_sync", rx_sync, m_a[4]);
    chk("R8 irq", irq, (m_a[5] && e_rx_req()) || (m_a[6] && m_a[3]));
    chk("R4 in_ready", in_ready, m_a[4] && q.size() < 64);
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    case (a)
      3'd0: m_a = d;
      3'd1: m_b = d;
      3'd2: m_c = d;
      default: ;
    endcase
    check_flags();  // R9: visible one cycle after the write edge
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    #0.5 v = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic rd_data();
    logic [7:0] v, e;
    rd_reg(3'd5, v);
    e = (q.size() != 0) ? q.pop_front() : 8'h00;
    chk("R3 data order/empty read", v, e);
    check_flags();
  endtask

  task automatic rd_status();
    logic [7:0] v;
    rd_reg(3'd3, v); chk("R5 status A", v, e_stat_a());
    rd_reg(3'd4, v); chk("R7 status B", v, e_stat_b());
  endtask

  task automatic push(input logic [7:0] d);
    logic rdy;
    @(negedge clk);
    in_valid = 1'b1; in_data = d;
    #0.5 rdy = in_ready;
    chk("R4 ready before push", rdy, m_a[4] && q.size() < 64);
    @(negedge clk);
    in_valid = 1'b0;
    if (m_a[4] && q.size() < 64) q.push_back(d);
    check_flags();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'h1234_5EED));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    for (int a = 0; a < 5; a++) begin
      rd_reg(3'(a), v);
      chk("R1 reset register", v, 8'h00);
    end
    chk("R1 in_ready", in_ready, 1'b0);
    chk("R1 irq", irq, 1'b0);
    check_flags();
    // R2 readback and ignored status writes
    wr_reg(3'd0, 8'hA5); wr_reg(3'd1, 8'h3C); wr_reg(3'd2, 8'hC6);
    rd_reg(3'd0, v); chk("R2 ctl A", v, 8'hA5);
    rd_reg(3'd1, v); chk("R2 ctl B", v, 8'h3C);
    rd_reg(3'd2, v); chk("R2 ctl C", v, 8'hC6);
    wr_reg(3'd3, 8'hFF); wr_reg(3'd4, 8'hFF);
    rd_status();
    rd_reg(3'd0, v); chk("R2 ctl A after status write", v, 8'hA5);
    // R3 empty read
    wr_reg(3'd0, 8'h10); wr_reg(3'd2, 8'h00);
    rd_data();
    // R5 thresholds
    for (int i = 0; i < 7; i++) push(8'(i + 1));
    chk("R5 code0 at 7", rx_req, 1'b0);
    push(8'h08);
    chk("R5 code0 at 8", rx_req, 1'b1);
    wr_reg(3'd2, 8'h01); chk("R5 code1 at 8", rx_req, 1'b0);
    wr_reg(3'd2, 8'h02); chk("R5 code2 at 8", rx_req, 1'b0);
    wr_reg(3'd2, 8'h03); chk("R5 code3 at 8", rx_req, 1'b1);
    wr_reg(3'd2, 8'h02);
    for (int i = 8; i < 64; i++) push(8'(i * 3 + 1));
    chk("R4 full ready low", in_ready, 1'b0);
    push(8'hEE);  // 65th byte rejected
    rd_status();
    for (int i = 0; i < 64; i++) rd_data();
    rd_data();
    wr_reg(3'd2, 8'h03); chk("R5 code3 empty", rx_req, 1'b1);
    // R8 interrupt combinations
    wr_reg(3'd0, 8'h48); chk("R8 tx irq", irq, 1'b1);
    wr_reg(3'd0, 8'h40); chk("R8 tx ie only", irq, 1'b0);
    wr_reg(3'd0, 8'h30); chk("R8 rx irq", irq, 1'b1);
    // R4 disabled receiver
    wr_reg(3'd0, 8'h00); push(8'h55); chk("R4 disabled no store", not_empty, 1'b0);
    // random phase
    for (int k = 0; k < 1500; k++) begin
      int r;
      r = $urandom % 12;
      if (r < 6) push(8'($urandom));
      else if (r < 9) rd_data();
      else if (r == 9) wr_reg(3'd0, 8'($urandom) | ((($urandom % 4) != 0) ? 8'h10 : 8'h00));
      else if (r == 10) wr_reg(3'd2, 8'($urandom));
      else rd_status();
    end
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule